// File: doc/BRIEF.md
# Programmable 54-Bit Alarm Timer

A free-running time base for a larger chip. A 54-bit counter steps up or down once per prescaled tick, and a 16-bit divider sets the tick rate. An armed compare value raises a one-cycle alarm pulse toward an external interrupt status register. An optional automatic reload restarts the count from a programmed start value at each alarm.

Software drives the block through a plain word-wide register port: a write strobe with address and data, and a combinational read port. The live count cannot be read directly. A write to the capture command copies it into two read-only words. A write to the load command forces the reload value into the counter at once. All control and status pins are single-cycle strobes or levels, and there is no back-pressure: every write is taken on the clock edge where `wr_en` is high.

Top module: `tick_alarm_timer`

## Requirements
- R1: After reset, the control word at address 0 reads 0x0000800C. Its fields are run [31], divisor [30:15], prescaler-clear strobe [4] (always reads 0), direction [3] (1 = up), auto-reload [2], alarm arm [1] and source select [0]. Run resets to 0, divisor to 1, direction to 1, auto-reload to 1, arm to 0 and source select to 0. Both capture words read 0.
- R2: Each tick adds 1 to the counter when direction is 1 and subtracts 1 when it is 0. The counter wraps modulo 2^54 in both directions, with the carry crossing from the low word into the high word.
- R3: With divisor D, a tick occurs once every D clocks while run is 1, and D = 0 means once every 65536 clocks. While run is 0 the counter holds its value. After the write that sets run, the counter's value N clocks later is start ± floor(N/D).
- R4: Writing the control word with bit 4 set returns the prescaler's divide counter to zero, so the first tick after the next start comes a full D clocks later.
- R5: Any write to address 3 copies the live counter into the capture words: the low 32 bits at address 1 and the high 22 bits at address 2 (bits 21:0, upper bits 0). The capture holds the counter value from the cycle of that write.
- R6: When arm is 1 and a tick brings the counter to exactly the 54-bit alarm value (low word at address 4, high word at address 5), `alarm_pulse` is high for exactly one cycle, in the cycle the counter takes that value. Arm then reads 0. With arm 0 no pulse occurs.
- R7: With auto-reload 1, the alarm edge loads the counter with the 54-bit reload value (low word at address 6, high word at address 7) instead of the matching value.
- R8: With auto-reload 0, the counter keeps the matching value after the alarm and continues counting.
- R9: Any write to address 8 loads the reload value into the counter on that clock edge, and this takes priority over a tick.
- R10: The source select bit is stored and read back and has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| alarm_pulse | output | 1 | One-cycle alarm event |

## Verification
A write takes effect at the clock edge that samples it. A capture therefore returns the count from before that edge, and a forced load appears in the next capture unchanged. The counter first moves D edges after the starting write, so a capture issued after N idle cycles holds start ± floor(N/D), and the bench computes exactly that value. The alarm pulse appears in the first cycle that the counter holds the match (or the reload value). The bench counts pulse cycles at falling edges over the whole run window, which catches both a missing pulse and one that lasts two cycles. Reads are combinational and are sampled one time step after a falling edge, away from any register update.

// File: rtl/tat_pkg.sv
package tat_pkg;
  localparam int WORD_W = 32;

  localparam logic [3:0] A_CTRL    = 4'd0;
  localparam logic [3:0] A_CAP_LO  = 4'd1;
  localparam logic [3:0] A_CAP_HI  = 4'd2;
  localparam logic [3:0] A_CAP_CMD = 4'd3;
  localparam logic [3:0] A_ALM_LO  = 4'd4;
  localparam logic [3:0] A_ALM_HI  = 4'd5;
  localparam logic [3:0] A_RLD_LO  = 4'd6;
  localparam logic [3:0] A_RLD_HI  = 4'd7;
  localparam logic [3:0] A_LOAD    = 4'd8;

  localparam int B_SRC   = 0;
  localparam int B_ARM   = 1;
  localparam int B_AUTO  = 2;
  localparam int B_UP    = 3;
  localparam int B_CLR   = 4;
  localparam int B_DIV   = 15;
  localparam int B_RUN   = 31;
endpackage

// File: rtl/tat_prescaler.sv
module tat_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  // divisor 0 wraps to all-ones, giving a 2^DIV_W period
  assign lim  = divisor - 1'b1;
  assign tick = en && !clr && (cnt_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else if (en)     cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lim != '0) |=> (!tick || lim == '0)); // R3

  AST_CLEAR_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/tat_counter.sv
module tat_counter #(
  parameter int CNT_W = 54
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             up_i,
  input  logic             auto_i,
  input  logic             arm_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] alarm_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o,
  output logic             alarm_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nxt;

  assign nxt   = up_i ? cnt_q + 1'b1 : cnt_q - 1'b1;
  assign hit_o = tick_i && !load_i && arm_i && (nxt == alarm_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      alarm_o <= 1'b0;
    end else begin
      alarm_o <= hit_o;
      if (load_i)                cnt_q <= reload_i;
      else if (hit_o && auto_i)  cnt_q <= reload_i;
      else if (tick_i)           cnt_q <= nxt;
    end
  end

  AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(reload_i))); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q)); // R3

  AST_RELOAD_ON_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && auto_i) |=> (cnt_q == $past(reload_i))); // R7

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_o && !arm_i) |=> !alarm_o); // R6
endmodule

// File: rtl/tat_regs.sv
module tat_regs
  import tat_pkg::*;
#(
  parameter int CNT_W = 54,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [3:0]        rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              hit_i,
  output logic              run_o,
  output logic              up_o,
  output logic              auto_o,
  output logic              arm_o,
  output logic              div_clr_o,
  output logic              load_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [CNT_W-1:0]  alarm_o,
  output logic [CNT_W-1:0]  reload_o
);
  localparam int HI_W  = CNT_W - WORD_W;
  localparam int PAD_W = WORD_W - HI_W;

  logic             src_q;
  logic [CNT_W-1:0] snap_q;
  logic             ctrl_wr, snap_wr;
  logic [WORD_W-1:0] ctrl_rd;

  assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
  assign snap_wr   = wr_en && (wr_addr == A_CAP_CMD);
  assign load_o    = wr_en && (wr_addr == A_LOAD);
  assign div_clr_o = ctrl_wr && wr_data[B_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_o    <= 1'b0;
      up_o     <= 1'b1;
      auto_o   <= 1'b1;
      arm_o    <= 1'b0;
      src_q    <= 1'b0;
      div_o    <= DIV_W'(1);
      alarm_o  <= '0;
      reload_o <= '0;
      snap_q   <= '0;
    end else begin
      if (ctrl_wr) begin
        run_o  <= wr_data[B_RUN];
        up_o   <= wr_data[B_UP];
        auto_o <= wr_data[B_AUTO];
        arm_o  <= wr_data[B_ARM];
        src_q  <= wr_data[B_SRC];
        div_o  <= wr_data[B_DIV +: DIV_W];
      end else if (hit_i) begin
        arm_o  <= 1'b0;
      end
      if (snap_wr) snap_q <= cnt_i;
      if (wr_en) begin
        case (wr_addr)
          A_ALM_LO: alarm_o[WORD_W-1:0]      <= wr_data;
          A_ALM_HI: alarm_o[CNT_W-1:WORD_W]  <= wr_data[HI_W-1:0];
          A_RLD_LO: reload_o[WORD_W-1:0]     <= wr_data;
          A_RLD_HI: reload_o[CNT_W-1:WORD_W] <= wr_data[HI_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    ctrl_rd        = '0;
    ctrl_rd[B_RUN] = run_o;
    ctrl_rd[B_DIV +: DIV_W] = div_o;
    ctrl_rd[B_UP]  = up_o;
    ctrl_rd[B_AUTO] = auto_o;
    ctrl_rd[B_ARM] = arm_o;
    ctrl_rd[B_SRC] = src_q;
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:   rd_data = ctrl_rd;
      A_CAP_LO: rd_data = snap_q[WORD_W-1:0];
      A_CAP_HI: rd_data = {{PAD_W{1'b0}}, snap_q[CNT_W-1:WORD_W]};
      A_ALM_LO: rd_data = alarm_o[WORD_W-1:0];
      A_ALM_HI: rd_data = {{PAD_W{1'b0}}, alarm_o[CNT_W-1:WORD_W]};
      A_RLD_LO: rd_data = reload_o[WORD_W-1:0];
      A_RLD_HI: rd_data = {{PAD_W{1'b0}}, reload_o[CNT_W-1:WORD_W]};
      default:  rd_data = '0;
    endcase
  end

  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_wr |=> (snap_q == $past(cnt_i))); // R5

  AST_ARM_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && !ctrl_wr) |=> !arm_o); // R6
endmodule

// File: rtl/tick_alarm_timer.sv
module tick_alarm_timer
  import tat_pkg::*;
#(
  parameter int CNT_W = 54,
  parameter int DIV_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [3:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        alarm_pulse
);
  logic             run, up, auto_rl, arm, div_clr, load, tick, hit;
  logic [DIV_W-1:0] divisor;
  logic [CNT_W-1:0] alarm_val, reload_val, cnt;

  tat_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cnt_i(cnt), .hit_i(hit), .run_o(run), .up_o(up), .auto_o(auto_rl),
    .arm_o(arm), .div_clr_o(div_clr), .load_o(load), .div_o(divisor),
    .alarm_o(alarm_val), .reload_o(reload_val)
  );

  tat_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(run), .clr(div_clr),
    .divisor(divisor), .tick(tick)
  );

  tat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .up_i(up), .auto_i(auto_rl),
    .arm_i(arm), .load_i(load), .alarm_i(alarm_val), .reload_i(reload_val),
    .cnt_o(cnt), .hit_o(hit), .alarm_o(alarm_pulse)
  );
endmodule

// File: tb/sim_tick_alarm_timer.sv
`timescale 1ns/1ps
module sim_tick_alarm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        alarm_pulse;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tick_alarm_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .alarm_pulse(alarm_pulse)
  );

  always @(negedge clk) if (alarm_pulse) pulses++;

  localparam int NV = 6;
  localparam logic [53:0] V_START [NV] = '{54'd0, 54'd7, 54'd100, 54'd5,
                                           {54{1'b1}}, 54'h1_FFFF_FFFF};
  localparam logic [15:0] V_DIV [NV] = '{16'd1, 16'd0, 16'd3, 16'd1, 16'd1, 16'd2};
  localparam bit          V_UP  [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam int          V_N   [NV] = '{10, 50, 10, 7, 2, 4};

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic rd_snap(output logic [53:0] v);
    logic [31:0] lo, hi;
    rd(4'd1, lo);
    rd(4'd2, hi);
    v = {hi[21:0], lo};
  endtask

  function automatic logic [31:0] ctrl(input bit run, input logic [15:0] dv,
      input bit clr, input bit up, input bit au, input bit arm, input bit src);
    return {run, dv, 10'd0, clr, up, au, arm, src};
  endfunction

  task automatic prep(input logic [53:0] start);
    wr(4'd0, ctrl(0, 16'd1, 1, 1, 1, 0, 0));
    wr(4'd6, start[31:0]);
    wr(4'd7, {10'd0, start[53:32]});
    wr(4'd8, 32'hAB);
  endtask

  task automatic alarm_case(input string req, input bit au, input bit arm,
                            input logic [53:0] exp, input int exp_p);
    logic [53:0] s;
    logic [31:0] c;
    prep(54'd990);
    wr(4'd4, 32'd995);
    wr(4'd5, 32'd0);
    wr(4'd6, 32'd1000);
    pulses = 0;
    wr(4'd0, ctrl(1, 16'd1, 0, 1, au, arm, 0));
    repeat (20) @(negedge clk);
    wr(4'd3, 32'd0);
    rd_snap(s);
    chk(req, {10'd0, s}, {10'd0, exp});
    chk(req, pulses, exp_p);
    rd(4'd0, c);
    chk(req, c[1], 0);
  endtask

  initial begin
    logic [31:0] d;
    logic [53:0] s, s2, exp;
    int dd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, d); chk("R1 ctrl reset", d, 32'h0000_800C);
    rd(4'd1, d); chk("R1 cap lo reset", d, 0);
    rd(4'd2, d); chk("R1 cap hi reset", d, 0);

    // R2 R3 R4 R5 vector walk
    for (int i = 0; i < NV; i++) begin
      prep(V_START[i]);
      wr(4'd0, ctrl(1, V_DIV[i], 0, V_UP[i], 1, 0, 0));
      repeat (V_N[i]) @(negedge clk);
      wr(4'd3, 32'd0);
      rd_snap(s);
      dd  = (V_DIV[i] == 0) ? 65536 : int'(V_DIV[i]);
      exp = V_UP[i] ? V_START[i] + 54'(V_N[i] / dd) : V_START[i] - 54'(V_N[i] / dd);
      chk($sformatf("R2 R3 R4 R5 vector %0d", i), {10'd0, s}, {10'd0, exp});
    end

    // R3 hold while stopped
    wr(4'd0, ctrl(0, 16'd1, 0, 1, 1, 0, 0));
    wr(4'd3, 32'd0);
    rd_snap(s);
    repeat (10) @(negedge clk);
    wr(4'd3, 32'd0);
    rd_snap(s2);
    chk("R3 hold when stopped", {10'd0, s2}, {10'd0, s});

    // R6 R7 alarm with auto-reload: 1000 + 20 - 5
    alarm_case("R6 R7 alarm auto-reload", 1, 1, 54'd1015, 1);
    // R8 alarm without reload
    alarm_case("R8 alarm no reload", 0, 1, 54'd1010, 1);
    // R6 unarmed: no pulse
    alarm_case("R6 unarmed", 1, 0, 54'd1010, 0);

    // R9 software load while running
    wr(4'd6, 32'd5);
    wr(4'd7, 32'h2A);
    wr(4'd8, 32'd0);
    wr(4'd3, 32'd0);
    rd_snap(s);
    chk("R9 software load", {10'd0, s}, {10'd0, 54'h2A_0000_0005});

    // R10 source select stored
    wr(4'd0, ctrl(0, 16'd1, 0, 1, 1, 0, 1));
    rd(4'd0, d);
    chk("R10 source bit", d[0], 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule